// File: doc/BRIEF.md
# Temperature Conversion Scheduler

This block decides when the analog side of a temperature sensor performs a conversion. It reads two mode bits from an 8-bit configuration byte and produces a power enable for the converter and a one-cycle start pulse. With neither mode bit set it keeps the converter powered and starts a conversion every `PERIOD_TICKS` ticks of a slow timebase. With the shutdown bit set it keeps the converter unpowered and never starts a conversion, while the register interface that feeds it stays fully usable.

With the one-shot bit set, and shutdown clear, the converter stays unpowered until the serial interface writes the trigger value to the pointer register. The block then raises the power enable, issues the start pulse on the next tick and lowers the power enable again when the converter signals that it has finished. The default period of 100 ticks gives a 100 ms cadence when the tick input is a 1 ms strobe.

Top module: `conv_sched`

## Requirements
- R1: While reset is asserted, and in the cycle after reset is released with shutdown selected, `powerEn` and `convStart` are both 0.
- R2: While configuration bit 0 is 1, `powerEn` and `convStart` stay 0 whatever happens on `tick`, `ptrWrite`, `ptrByte` and `convDone`; clearing the bit restores the selected mode.
- R3: With configuration bits 0 and 5 both 0, `powerEn` is 1 from the cycle after the mode is entered, and `convStart` is 1 in the cycle after every `PERIOD_TICKS`-th tick counted from entry, and 0 otherwise.
- R4: Leaving continuous mode and entering it again restarts the tick count, so the next start follows a full `PERIOD_TICKS` ticks after re-entry.
- R5: With configuration bit 5 at 1 and bit 0 at 0, `powerEn` is 0 until a pointer write of 8'h04; the write raises `powerEn` in the following cycle.
- R6: In one-shot mode a pointer write of any value other than 8'h04 leaves `powerEn` and `convStart` at 0.
- R7: After a one-shot trigger, `convStart` is 1 for exactly one cycle, in the cycle after the first tick that follows the trigger write.
- R8: In one-shot mode, `powerEn` returns to 0 in the cycle after `convDone` is seen during a conversion, and a later 8'h04 write starts a new conversion.
- R9: A trigger write that arrives while a one-shot conversion is pending or running does not produce a second start pulse.
- R10: When configuration bits 0 and 5 are both 1, shutdown wins: a trigger write raises neither output.
- R11: Configuration bits 1, 2, 3, 4, 6 and 7 have no effect on either output.
- R12: `convStart` is never 1 in two consecutive cycles, and `powerEn` is 1 in the cycle before and the cycle of every start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgReg | input | 8 | Configuration byte; bit 0 shutdown, bit 5 one-shot |
| ptrWrite | input | 1 | One-cycle strobe: the pointer register is being written |
| ptrByte | input | 8 | Byte written to the pointer register |
| tick | input | 1 | One-cycle timebase strobe |
| convDone | input | 1 | Converter reports the end of a conversion |
| powerEn | output | 1 | Converter power enable |
| convStart | output | 1 | One-cycle conversion start pulse |

## Verification
The bench writes all 256 pointer values in one-shot mode; a decoder that matched too few bits of the trigger byte would power the converter on a wrong value, and one that missed the trigger would never raise the enable. It runs continuous mode under several tick spacings and configuration bytes with the unused bits set, predicting each start from a tick count, so an off-by-one period or a count that survives leaving and re-entering the mode shows up as a pulse one or more ticks early or late. It also fires a second trigger during a running conversion and sets shutdown and one-shot together, where a design that queued triggers or let one-shot win would emit an extra start or power the converter.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;

  localparam int CFG_SHUTDOWN_BIT = 0;
  localparam int CFG_ONESHOT_BIT  = 5;

  typedef enum logic [1:0] {
    ST_OFF,   // converter unpowered
    ST_RUN,   // continuous conversions
    ST_ARM,   // one-shot: powered, waiting for a tick
    ST_BUSY   // one-shot: conversion in progress
  } schedState_t;

  typedef struct packed {
    logic cntClear;
    logic cntAdvance;
  } cntCtl_t;

endpackage

// File: rtl/conv_sched_dp.sv
module conv_sched_dp
  import conv_sched_pkg::*;
#(
  parameter int PERIOD_TICKS = 100
) (
  input  logic    clk,
  input  logic    rstN,
  input  cntCtl_t cntCtl,
  output logic    periodHit
);

  localparam int CNT_W = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD_TICKS - 1);

  logic [CNT_W-1:0] tickCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCount <= '0;
    end else if (cntCtl.cntClear) begin
      tickCount <= '0;
    end else if (cntCtl.cntAdvance) begin
      tickCount <= (tickCount == CNT_LAST) ? '0 : tickCount + 1'b1;
    end
  end

  assign periodHit = cntCtl.cntAdvance && (tickCount == CNT_LAST);

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    tickCount <= CNT_LAST); // R3

  AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    cntCtl.cntClear |=> (tickCount == '0)); // R4

endmodule

// File: rtl/conv_sched_ctrl.sv
module conv_sched_ctrl
  import conv_sched_pkg::*;
#(
  parameter logic [7:0] TRIGGER_PTR = 8'h04
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] cfgReg,
  input  logic       ptrWrite,
  input  logic [7:0] ptrByte,
  input  logic       tick,
  input  logic       convDone,
  input  logic       periodHit,
  output cntCtl_t    cntCtl,
  output logic       powerEn,
  output logic       convStart
);

  schedState_t state, stateNext;
  logic        startQ, startNext;
  logic        shutdownMode, oneShotMode, contMode, trigHit;

  assign shutdownMode = cfgReg[CFG_SHUTDOWN_BIT];
  assign oneShotMode  = !shutdownMode && cfgReg[CFG_ONESHOT_BIT];
  assign contMode     = !shutdownMode && !cfgReg[CFG_ONESHOT_BIT];
  assign trigHit      = ptrWrite && (ptrByte == TRIGGER_PTR);

  always_comb begin
    stateNext = state;
    startNext = 1'b0;
    if (shutdownMode) begin
      stateNext = ST_OFF;
    end else if (contMode) begin
      stateNext = ST_RUN;
      startNext = (state == ST_RUN) && periodHit;
    end else begin
      unique case (state)
        ST_RUN:  stateNext = ST_OFF;
        ST_OFF:  if (trigHit) stateNext = ST_ARM;
        ST_ARM:  if (tick) begin
                   stateNext = ST_BUSY;
                   startNext = 1'b1;
                 end
        ST_BUSY: if (convDone) stateNext = ST_OFF;
        default: stateNext = ST_OFF;
      endcase
    end
  end

  always_comb begin
    cntCtl.cntClear   = (state != ST_RUN);
    cntCtl.cntAdvance = (state == ST_RUN) && contMode && tick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_OFF;
      startQ <= 1'b0;
    end else begin
      state  <= stateNext;
      startQ <= startNext;
    end
  end

  assign powerEn   = (state != ST_OFF);
  assign convStart = startQ;

  AST_SHUTDOWN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    shutdownMode |=> (!powerEn && !convStart)); // R2

  AST_BAD_PTR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (oneShotMode && state == ST_OFF && !trigHit) |=> (!powerEn && !convStart)); // R6

  AST_ARM_THEN_START: assert property (@(posedge clk) disable iff (!rstN)
    (oneShotMode && state == ST_ARM && tick) |=> convStart); // R7

  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY) |=> !convStart); // R9

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R12

  AST_POWER_AROUND_START: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> (powerEn && $past(powerEn))); // R12

endmodule

// File: rtl/conv_sched.sv
module conv_sched
  import conv_sched_pkg::*;
#(
  parameter int         PERIOD_TICKS = 100,
  parameter logic [7:0] TRIGGER_PTR  = 8'h04
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] cfgReg,
  input  logic       ptrWrite,
  input  logic [7:0] ptrByte,
  input  logic       tick,
  input  logic       convDone,
  output logic       powerEn,
  output logic       convStart
);

  cntCtl_t cntCtl;
  logic    periodHit;

  conv_sched_ctrl #(
    .TRIGGER_PTR(TRIGGER_PTR)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgReg    (cfgReg),
    .ptrWrite  (ptrWrite),
    .ptrByte   (ptrByte),
    .tick      (tick),
    .convDone  (convDone),
    .periodHit (periodHit),
    .cntCtl    (cntCtl),
    .powerEn   (powerEn),
    .convStart (convStart)
  );

  conv_sched_dp #(
    .PERIOD_TICKS(PERIOD_TICKS)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cntCtl    (cntCtl),
    .periodHit (periodHit)
  );

endmodule

// File: tb/test_conv_sched.sv
module test_conv_sched;

  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] cfgReg = 8'h01;
  logic       ptrWrite = 1'b0;
  logic [7:0] ptrByte = 8'h00;
  logic       tick = 1'b0;
  logic       convDone = 1'b0;
  logic       powerEn, convStart;

  int total = 0;
  int bad = 0;
  int tickSeen = 0;

  always #4 clk = ~clk;

  conv_sched #(.PERIOD_TICKS(P)) i_conv_sched (
    .clk(clk), .rstN(rstN), .cfgReg(cfgReg), .ptrWrite(ptrWrite),
    .ptrByte(ptrByte), .tick(tick), .convDone(convDone),
    .powerEn(powerEn), .convStart(convStart)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // drive inputs, take one clock edge, sample 2 ns after it
  task automatic step(input logic t, input logic w, input logic [7:0] b, input logic d);
    tick = t; ptrWrite = w; ptrByte = b; convDone = d;
    @(posedge clk);
    #2;
    tick = 1'b0; ptrWrite = 1'b0; convDone = 1'b0;
  endtask

  task automatic enterCont(input logic [7:0] cfg);
    cfgReg = 8'h01;
    step(0, 0, 0, 0);
    cfgReg = cfg;
    step(1, 0, 0, 0);           // entry edge: tick here is not counted
    chk("R3", "powerEn on entry", powerEn, 1'b1);
    tickSeen = 0;
  endtask

  task automatic runCont(input int steps, input int gap);
    for (int i = 0; i < steps; i++) begin
      logic t;
      t = ((i % gap) == 0);
      step(t, 0, 8'h04, 0);
      if (t) tickSeen++;
      chk("R3", "convStart cadence", convStart, t && (tickSeen % P == 0));
      chk("R3", "powerEn held", powerEn, 1'b1);
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "powerEn in reset", powerEn, 1'b0);
    chk("R1", "convStart in reset", convStart, 1'b0);
    rstN = 1'b1;
    step(1, 1, 8'h04, 0);
    chk("R1", "powerEn after reset", powerEn, 1'b0);
    chk("R1", "convStart after reset", convStart, 1'b0);

    // R2: shutdown keeps everything low
    for (int i = 0; i < 3 * P; i++) begin
      step(1, 1, 8'h04, i[0]);
      chk("R2", "powerEn in shutdown", powerEn, 1'b0);
      chk("R2", "convStart in shutdown", convStart, 1'b0);
    end

    // R3 / R11: continuous cadence, several spacings and ignored bits
    enterCont(8'h00); runCont(6 * P, 1);
    enterCont(8'h00); runCont(5 * P * 3, 3);
    enterCont(8'hDE); runCont(4 * P * 2, 2);   // R11 bits 1-4,6,7 set
    enterCont(8'h40); runCont(3 * P, 1);       // R11 reserved bit 6 alone

    // R2: leaving shutdown restores continuous operation
    cfgReg = 8'h01; step(0, 0, 0, 0);
    chk("R2", "powerEn during shutdown", powerEn, 1'b0);
    cfgReg = 8'h00; step(0, 0, 0, 0);
    chk("R2", "powerEn restored", powerEn, 1'b1);

    // R4: re-entry restarts the count
    enterCont(8'h00);
    step(1, 0, 0, 0); step(1, 0, 0, 0);
    chk("R4", "no start after two ticks", convStart, 1'b0);
    cfgReg = 8'h20; step(0, 0, 0, 0);
    chk("R5", "leaving continuous powers down", powerEn, 1'b0);
    cfgReg = 8'h00; step(0, 0, 0, 0);
    for (int k = 1; k <= P; k++) begin
      step(1, 0, 0, 0);
      chk("R4", "start only after full period", convStart, k == P);
    end

    // R5 / R6 / R7 / R8 / R9: sweep all pointer values in one-shot mode
    cfgReg = 8'h20; step(0, 0, 0, 0);
    for (int b = 0; b < 256; b++) begin
      step(0, 1, 8'(b), 0);
      if (b != 4) begin
        chk("R6", "wrong pointer no power", powerEn, 1'b0);
        step(1, 0, 0, 0);
        chk("R6", "wrong pointer no start", convStart, 1'b0);
      end else begin
        chk("R5", "trigger powers up", powerEn, 1'b1);
        chk("R5", "no start before tick", convStart, 1'b0);
        step(0, 1, 8'h04, 0);
        chk("R9", "retrigger while armed", convStart, 1'b0);
        step(1, 0, 0, 0);
        chk("R7", "start after tick", convStart, 1'b1);
        step(1, 1, 8'h04, 0);
        chk("R7", "start one cycle", convStart, 1'b0);
        chk("R9", "busy keeps power", powerEn, 1'b1);
        step(1, 0, 0, 0);
        chk("R9", "no second start", convStart, 1'b0);
        step(0, 0, 0, 1);
        chk("R8", "done powers down", powerEn, 1'b0);
        step(1, 0, 0, 0);
        chk("R8", "idle after done", convStart, 1'b0);
      end
    end

    // R8: a second one-shot after completion, with ignored bits set (R11)
    cfgReg = 8'hFE; step(0, 0, 0, 0);
    chk("R11", "one-shot idle with extra bits", powerEn, 1'b0);
    step(0, 1, 8'h04, 0);
    chk("R8", "re-trigger powers up", powerEn, 1'b1);
    step(1, 0, 0, 0);
    chk("R8", "re-trigger starts", convStart, 1'b1);
    step(0, 0, 0, 1);
    chk("R8", "second done powers down", powerEn, 1'b0);

    // R10: shutdown beats one-shot
    cfgReg = 8'h21; step(0, 0, 0, 0);
    for (int i = 0; i < 2 * P; i++) begin
      step(i[0], 1, 8'h04, 0);
      chk("R10", "powerEn with both bits", powerEn, 1'b0);
      chk("R10", "convStart with both bits", convStart, 1'b0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule